// File: doc/BRIEF.md
# Adaptive Monte-Carlo Diversity Estimator

This block estimates, by random simulation, the diversity value of one fault pair in a duplicated design. An internal maximal-length shift-register generator produces input patterns and presents them on a pattern bus to an attached checker. The checker holds the fault-free circuit and the two faulty copies. For each pattern it returns one bit: high when the pattern is "good" and low when both faulty copies produced the same wrong output. Good means that both copies are correct, or that their errors differ.

A run is started with a pulse on `start`. It consists of M experiments of N patterns each, where M and N are powers of two chosen by their base-2 logarithms. The per-experiment estimate is the fraction of good patterns, as a 1.16 unsigned fixed-point number. The estimates are written into a small result memory. Once every experiment has finished, the memory is read back and reduced by an adaptive rule. If any experiment scored below one half, the answer is the smallest estimate, because low values matter only as a pessimistic bound. Otherwise the answer is the mean of the estimates. The checker may answer with any latency, and it may leave gaps between its answers.

Top module: `mc_diversity_est`

## Requirements
- R1: After reset, `busy`, `done` and `pat_valid` are low and `result` is zero.
- R2: A `start` pulse while idle raises `busy` in the next cycle and presents `cfg_seed` as the first pattern. A seed of zero is replaced by the value 1.
- R3: Each pattern is followed by `{p[W-2:0], ^(p & MASK)}`, with MASK 8'hB8 for 8-bit patterns and 16'hD008 for 16-bit patterns. `pat_data` only advances on a cycle with `pat_valid` high. It is never zero while busy, and it is not reloaded between experiments.
- R4: A run issues exactly M*N patterns, with N = 2^`cfg_log_n` and M = 2^`cfg_log_m`. An experiment issues no pattern until all N responses of the previous experiment have arrived, and `pat_valid` is only high while busy.
- R5: A response counts only in a cycle with `chk_valid` high. `chk_good` is ignored while `chk_valid` is low. An experiment ends at its Nth valid response, whatever the checker latency.
- R6: An experiment's estimate is good_count * 2^16 / N, so that the value 1.0 reads as 17'h10000. `result` never exceeds 17'h10000.
- R7: If any experiment has 2*good_count < N, then `result` is the smallest of the M estimates.
- R8: Otherwise `result` is the mean of the M estimates, rounded down. An experiment with exactly N/2 good patterns does not trigger the minimum rule.
- R9: `done` is high for exactly one cycle, with `busy` low. `result` changes only in that cycle and holds until the next run's `done`.
- R10: A `start` pulse while busy has no effect on the patterns, the configuration or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| cfg_seed | input | PAT_W | Generator seed, loaded at start |
| cfg_log_n | input | LN_W | log2 of patterns per experiment (clamped to LOG_N_MAX) |
| cfg_log_m | input | LM_W | log2 of experiment count (clamped to LOG_M_MAX) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | FRAC_W+1 | Final estimate, unsigned 1.16 fixed point |
| pat_valid | output | 1 | Pattern on pat_data is issued this cycle |
| pat_data | output | PAT_W | Input pattern for the checker |
| chk_valid | input | 1 | Checker response valid |
| chk_good | input | 1 | Response: 1 good, 0 identical error |

## Verification
The bench builds the block with 8-bit patterns, LOG_N_MAX = 6 and LOG_M_MAX = 3. This keeps every run short, and it still fills the whole eight-entry result memory and reaches the single-pattern, single-experiment corner. The short generator period lets the reference model check every emitted pattern against the feedback rule across experiment boundaries. The bench drives the checker side with several latencies and with periodic gaps, and it drives `chk_good` high while invalid. It shapes the good counts so that one experiment sits at exactly N/2 and another falls just below N/2, which exercises both sides of the adaptive rule.

// File: rtl/mcde_pkg.sv
package mcde_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_REDUCE,
    ST_FINAL
  } est_state_t;

  // Feedback masks for maximal-length sequences with a left-shifting register
  function automatic logic [63:0] lfsr_mask(input int unsigned w);
    case (w)
      3:       return 64'h6;
      4:       return 64'hC;
      5:       return 64'h14;
      6:       return 64'h30;
      7:       return 64'h60;
      8:       return 64'hB8;
      9:       return 64'h110;
      10:      return 64'h240;
      11:      return 64'h500;
      12:      return 64'h829;
      16:      return 64'hD008;
      20:      return 64'h90000;
      24:      return 64'hE10000;
      32:      return 64'h80200003;
      default: return 64'h3 << (w - 2);
    endcase
  endfunction

endpackage

// File: rtl/mcde_lfsr.sv
module mcde_lfsr
  import mcde_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);

  localparam logic [W-1:0] MASK = W'(lfsr_mask(W));

  logic fb;
  assign fb = ^(state & MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= W'(1);
    end else if (load) begin
      state <= (seed == '0) ? W'(1) : seed;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end

endmodule

// File: rtl/mcde_tally.sv
module mcde_tally #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          iss_fire,
  input  logic          rsp_valid,
  input  logic          rsp_good,
  input  logic [CW-1:0] n_total,
  output logic          iss_last,
  output logic          rsp_last,
  output logic [CW-1:0] good_now
);

  logic [CW-1:0] iss_cnt;
  logic [CW-1:0] rsp_cnt;
  logic [CW-1:0] good_cnt;

  assign iss_last = (iss_cnt == n_total - CW'(1));
  assign rsp_last = rsp_valid && (rsp_cnt == n_total - CW'(1));
  assign good_now = good_cnt + CW'(rsp_valid & rsp_good);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      iss_cnt  <= '0;
      rsp_cnt  <= '0;
      good_cnt <= '0;
    end else begin
      if (iss_fire) iss_cnt <= iss_cnt + CW'(1);
      if (rsp_valid) begin
        rsp_cnt  <= rsp_cnt + CW'(1);
        good_cnt <= good_now;
      end
    end
  end

endmodule

// File: rtl/mcde_result_mem.sv
module mcde_result_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 17
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mcde_reducer.sv
module mcde_reducer #(
  parameter int DW        = 17,
  parameter int LOG_M_MAX = 4,
  parameter int LM_W      = 3,
  parameter int FRAC_W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_est,
  input  logic [LM_W-1:0] log_m,
  output logic [DW-1:0]   final_est
);

  localparam int SUM_W = DW + LOG_M_MAX;
  localparam logic [DW-1:0] HALF = DW'(1) << (FRAC_W - 1);

  logic [DW-1:0]    min_q;
  logic [SUM_W-1:0] sum_q;
  logic             below_q;
  logic [SUM_W-1:0] mean_w;

  assign mean_w    = sum_q >> log_m;
  assign final_est = below_q ? min_q : DW'(mean_w);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      min_q   <= '1;
      sum_q   <= '0;
      below_q <= 1'b0;
    end else if (in_valid) begin
      if (in_est < min_q) min_q <= in_est;
      sum_q <= sum_q + SUM_W'(in_est);
      if (in_est < HALF) below_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mc_diversity_est.sv
module mc_diversity_est
  import mcde_pkg::*;
#(
  parameter int PAT_W     = 16,
  parameter int LOG_N_MAX = 12,
  parameter int LOG_M_MAX = 4,
  parameter int FRAC_W    = 16,
  localparam int LN_W     = $clog2(LOG_N_MAX + 1),
  localparam int LM_W     = $clog2(LOG_M_MAX + 1),
  localparam int RES_W    = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAT_W-1:0] cfg_seed,
  input  logic [LN_W-1:0]  cfg_log_n,
  input  logic [LM_W-1:0]  cfg_log_m,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             pat_valid,
  output logic [PAT_W-1:0] pat_data,
  input  logic             chk_valid,
  input  logic             chk_good
);

  localparam int N_CNT_W = LOG_N_MAX + 1;
  localparam int M_MAX   = 1 << LOG_M_MAX;
  localparam int AW      = LOG_M_MAX;
  localparam int M_CNT_W = LOG_M_MAX + 1;
  localparam int SH_W    = $clog2(FRAC_W + 1);

  est_state_t       state;
  logic             busy_q;
  logic             done_q;
  logic [RES_W-1:0] result_q;
  logic             pat_valid_q;
  logic [LN_W-1:0]  ln_q;
  logic [LM_W-1:0]  lm_q;
  logic [M_CNT_W-1:0] exp_idx;
  logic [AW-1:0]    rd_addr;
  logic             rd_active;
  logic             rd_vld;
  logic             rd_last;

  logic               start_acc;
  logic [LN_W-1:0]    ln_clamp;
  logic [LM_W-1:0]    lm_clamp;
  logic [N_CNT_W-1:0] n_total;
  logic [M_CNT_W-1:0] m_last;
  logic               tally_clear;
  logic               rsp_valid_run;
  logic               iss_last;
  logic               rsp_last;
  logic [N_CNT_W-1:0] good_now;
  logic [SH_W-1:0]    shamt;
  logic [RES_W-1:0]   est_w;
  logic               exp_end;
  logic [RES_W-1:0]   mem_rdata;
  logic [RES_W-1:0]   final_est;

  assign start_acc = (state == ST_IDLE) && start;
  assign ln_clamp  = (cfg_log_n > LN_W'(LOG_N_MAX)) ? LN_W'(LOG_N_MAX) : cfg_log_n;
  assign lm_clamp  = (cfg_log_m > LM_W'(LOG_M_MAX)) ? LM_W'(LOG_M_MAX) : cfg_log_m;
  assign n_total   = N_CNT_W'(1) << ln_q;
  assign m_last    = (M_CNT_W'(1) << lm_q) - M_CNT_W'(1);

  assign rsp_valid_run = (state == ST_RUN) && chk_valid;
  assign exp_end       = (state == ST_RUN) && rsp_last;
  assign tally_clear   = start_acc || exp_end;

  // Fraction of good patterns: count scaled by 2^FRAC_W / N
  assign shamt = SH_W'(FRAC_W) - SH_W'(ln_q);
  assign est_w = RES_W'(good_now) << shamt;

  mcde_lfsr #(
    .W (PAT_W)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (start_acc),
    .seed  (cfg_seed),
    .step  (pat_valid_q),
    .state (pat_data)
  );

  mcde_tally #(
    .CW (N_CNT_W)
  ) u_tally (
    .clk       (clk),
    .rst       (rst),
    .clear     (tally_clear),
    .iss_fire  (pat_valid_q),
    .rsp_valid (rsp_valid_run),
    .rsp_good  (chk_good),
    .n_total   (n_total),
    .iss_last  (iss_last),
    .rsp_last  (rsp_last),
    .good_now  (good_now)
  );

  mcde_result_mem #(
    .DEPTH (M_MAX),
    .AW    (AW),
    .DW    (RES_W)
  ) u_mem (
    .clk   (clk),
    .we    (exp_end),
    .waddr (exp_idx[AW-1:0]),
    .wdata (est_w),
    .raddr (rd_addr),
    .rdata (mem_rdata)
  );

  mcde_reducer #(
    .DW        (RES_W),
    .LOG_M_MAX (LOG_M_MAX),
    .LM_W      (LM_W),
    .FRAC_W    (FRAC_W)
  ) u_reduce (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_acc),
    .in_valid  (rd_vld),
    .in_est    (mem_rdata),
    .log_m     (lm_q),
    .final_est (final_est)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      result_q    <= '0;
      pat_valid_q <= 1'b0;
      ln_q        <= '0;
      lm_q        <= '0;
      exp_idx     <= '0;
      rd_addr     <= '0;
      rd_active   <= 1'b0;
      rd_vld      <= 1'b0;
      rd_last     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      rd_vld  <= 1'b0;
      rd_last <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ln_q        <= ln_clamp;
            lm_q        <= lm_clamp;
            exp_idx     <= '0;
            busy_q      <= 1'b1;
            pat_valid_q <= 1'b1;
            state       <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (pat_valid_q && iss_last) pat_valid_q <= 1'b0;
          if (rsp_last) begin
            if (exp_idx == m_last) begin
              state     <= ST_REDUCE;
              rd_addr   <= '0;
              rd_active <= 1'b1;
            end else begin
              exp_idx     <= exp_idx + M_CNT_W'(1);
              pat_valid_q <= 1'b1;
            end
          end
        end
        ST_REDUCE: begin
          rd_vld  <= rd_active;
          rd_last <= rd_active && ({1'b0, rd_addr} == m_last);
          if (rd_active) begin
            if ({1'b0, rd_addr} == m_last) rd_active <= 1'b0;
            else rd_addr <= rd_addr + AW'(1);
          end
          if (rd_vld && rd_last) state <= ST_FINAL;
        end
        ST_FINAL: begin
          result_q <= final_est;
          done_q   <= 1'b1;
          busy_q   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign result    = result_q;
  assign pat_valid = pat_valid_q;

endmodule

// File: rtl/mcde_checker.sv
module mcde_checker #(
  parameter int PAT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int RES_W  = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             pat_valid,
  input logic [PAT_W-1:0] pat_data,
  input logic [RES_W-1:0] result
);

  localparam logic [RES_W-1:0] ONE = RES_W'(1) << FRAC_W;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  p_issue_busy_r4: assert property (@(posedge clk) disable iff (rst)
    pat_valid |-> busy);

  p_pat_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pat_data != '0));

  p_pat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!pat_valid && !(start && !busy)) |=> $stable(pat_data));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && pat_valid) |=> busy);

  p_result_range_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (result <= ONE));

endmodule

bind mc_diversity_est mcde_checker #(
  .PAT_W  (PAT_W),
  .FRAC_W (FRAC_W),
  .RES_W  (RES_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .pat_valid (pat_valid),
  .pat_data  (pat_data),
  .result    (result)
);

// File: tb/tb_mc_diversity_est.sv
module tb_mc_diversity_est;

  localparam int PAT_W = 8;
  localparam int LNMAX = 6;
  localparam int LMMAX = 3;
  localparam int FRAC  = 16;
  localparam int LN_W  = $clog2(LNMAX + 1);
  localparam int LM_W  = $clog2(LMMAX + 1);
  localparam int RES_W = FRAC + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [PAT_W-1:0] cfg_seed = '0;
  logic [LN_W-1:0]  cfg_log_n = '0;
  logic [LM_W-1:0]  cfg_log_m = '0;
  logic             busy, done, pat_valid;
  logic [RES_W-1:0] result;
  logic [PAT_W-1:0] pat_data;
  logic             chk_valid = 1'b0;
  logic             chk_good = 1'b1;

  mc_diversity_est #(
    .PAT_W(PAT_W), .LOG_N_MAX(LNMAX), .LOG_M_MAX(LMMAX), .FRAC_W(FRAC)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_seed(cfg_seed),
    .cfg_log_n(cfg_log_n), .cfg_log_m(cfg_log_m), .busy(busy), .done(done),
    .result(result), .pat_valid(pat_valid), .pat_data(pat_data),
    .chk_valid(chk_valid), .chk_good(chk_good)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // reference model state
  logic [PAT_W-1:0] m_lfsr = 8'h01;
  int m_n = 1, m_m = 1, m_mode = 0, m_lat = 1, m_gap = 0;
  int iss_k = 0, rsp_k = 0;
  int gcnt [8];
  int q_good [$];
  int q_ts [$];
  logic [RES_W-1:0] last_result = '0;
  bit active = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int good_fn(input int k, input logic [PAT_W-1:0] p);
    int e, j;
    e = k / m_n;
    j = k % m_n;
    case (m_mode)
      0: return 1;
      1: return 0;
      2: return int'(p[0]);
      3: return (e == 2) ? int'(j < m_n / 2 - 1) : 1;
      default: return (e == 1) ? int'(j < m_n / 2) : 1;
    endcase
  endfunction

  function automatic longint exp_result();
    longint mn, sum, est;
    bit below;
    mn = 64'h7fffffff; sum = 0; below = 0;
    for (int e = 0; e < m_m; e++) begin
      est = longint'(gcnt[e]) * 65536 / m_n;
      if (est < mn) mn = est;
      sum += est;
      if (gcnt[e] * 2 < m_n) below = 1;
    end
    return below ? mn : sum / m_m;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Monitor, reference comparison and checker-side responder
  always @(negedge clk) begin
    if (!rst) begin
      if (!done && result !== last_result)
        chk(0, "R9", "result changed without done", result, last_result);
      if (done) begin
        chk(result == RES_W'(exp_result()), "R7/R8", "final result", result, exp_result());
        chk(busy == 1'b0, "R9", "busy with done", busy, 0);
        chk(iss_k == m_n * m_m, "R4", "patterns per run", iss_k, m_n * m_m);
        last_result = result;
        active = 1'b0;
      end
      if (pat_valid) begin
        int g;
        chk(pat_data == m_lfsr, "R3", "pattern sequence", pat_data, m_lfsr);
        if (iss_k % m_n == 0 && iss_k > 0)
          chk(rsp_k == iss_k, "R4", "experiment began before responses", rsp_k, iss_k);
        if (iss_k >= m_n * m_m)
          chk(0, "R4", "pattern beyond M*N", iss_k, m_n * m_m);
        else begin
          g = good_fn(iss_k, pat_data);
          gcnt[iss_k / m_n] += g;
          q_good.push_back(g);
          q_ts.push_back(cyc);
        end
        m_lfsr = {m_lfsr[PAT_W-2:0], ^(m_lfsr & 8'hB8)};
        iss_k++;
      end
      if (q_good.size() > 0 && cyc >= q_ts[0] + m_lat && (m_gap == 0 || cyc % 3 != 0)) begin
        chk_valid = 1'b1;
        chk_good = q_good[0][0];
        void'(q_good.pop_front());
        void'(q_ts.pop_front());
        rsp_k++;
      end else begin
        chk_valid = 1'b0;
        chk_good = 1'b1;  // junk while invalid (R5)
      end
    end
  end

  task automatic start_run(input logic [PAT_W-1:0] seed, input int ln, input int lm,
                           input int md, input int lt, input int gp);
    logic [PAT_W-1:0] first;
    @(negedge clk);
    first = (seed == 0) ? 8'h01 : seed;
    m_lfsr = first;
    m_n = 1 << ln; m_m = 1 << lm; m_mode = md; m_lat = lt; m_gap = gp;
    iss_k = 0; rsp_k = 0;
    for (int e = 0; e < 8; e++) gcnt[e] = 0;
    active = 1'b1;
    cfg_seed = seed; cfg_log_n = LN_W'(ln); cfg_log_m = LM_W'(lm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(pat_data == first, "R2", "first pattern is seed", pat_data, first);
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (done !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, "R4", {tag, " run completes"}, t, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(pat_valid == 0, "R1", "pat_valid after reset", pat_valid, 0);
    chk(result == 0, "R1", "result after reset", result, 0);

    // R6/R8: all good -> 1.0
    start_run(8'h5A, 4, 2, 0, 2, 0);
    wait_done("R6 all good");
    chk(result == 17'h10000, "R6", "all good gives 1.0", result, 17'h10000);

    // R5: none good, chk_good high while invalid must not count
    start_run(8'hC3, 3, 1, 1, 3, 1);
    wait_done("R5 none good");
    chk(result == 0, "R5", "invalid chk_good ignored", result, 0);

    // R7: one experiment just below half
    start_run(8'h11, 3, 2, 3, 1, 0);
    wait_done("R7 min rule");
    chk(result == 17'd24576, "R7", "minimum chosen", result, 24576);

    // R8: exactly half does not trigger minimum
    start_run(8'h99, 3, 2, 4, 4, 1);
    wait_done("R8 half boundary");
    chk(result == 17'd57344, "R8", "mean at half boundary", result, 57344);

    // R3/R4: pattern-driven goodness, larger run with gaps
    start_run(8'h27, 5, 3, 2, 4, 1);
    wait_done("R3 pattern mode");

    // R2: zero seed, single pattern single experiment
    start_run(8'h00, 0, 0, 2, 1, 0);
    wait_done("R2 zero seed");
    chk(result == 17'h10000, "R2", "seed 1 pattern good", result, 17'h10000);

    // R10: start while busy is ignored
    start_run(8'h6E, 4, 1, 2, 2, 0);
    repeat (4) @(negedge clk);
    cfg_seed = 8'h33; cfg_log_n = 1; cfg_log_m = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "still busy after ignored start", busy, 1);
    wait_done("R10 ignored start");

    // maximum N and M
    start_run(8'hE4, 6, 3, 2, 2, 0);
    wait_done("R4 max size");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule